// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers up to 32 peripheral interrupt sources into one request line towards the host core. A rising edge on a source line sets a sticky pending bit. A mask register decides which pending bits may raise the request. A control register holds a global enable, a request level for the core, one promoted vector, and four grouped priority slots that serial channels can be placed in.

When serving the request, the host writes the acknowledge bit of the vector register. The controller then freezes the number of the winning source, and the host reads it back from a 5-bit field. Vector 0 is never a real source. It is returned when the acknowledge finds nothing eligible, for example when a source was masked after it raised the request. The host retires a source by writing a one to its bit in the pending register.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_out` is 0 and `irq_level` is 0.
- R2: A rising edge on `src[i]` (i = 1..31) sets pending bit i one clock later. Pending bit 0 always reads 0.
- R3: A write to the pending register (address 2) clears exactly the bits written as 1. A new edge in the same cycle keeps its bit set.
- R4: The mask register (address 1) is read/write. Bit i = 1 lets pending source i take part in the request and in arbitration.
- R5: `irq_out` is 1 exactly when control bit 7 (enable) is 1 and some pending bit has its mask bit set. A write that removes the last such bit drops `irq_out` after that clock edge.
- R6: `irq_level` always equals control bits 15:13.
- R7: A write to address 3 with bit 0 = 1 latches the winning vector, whatever the enable bit is. Reading address 3 returns that vector at bits 15:11, with all other bits 0. The latched value holds until the next acknowledge.
- R8: Among eligible sources (pending and unmasked) that are neither promoted nor in a slot, the highest vector number wins.
- R9: A nonzero control field at bits 12:8 names a promoted vector that wins over every other eligible source.
- R10: Control bits 17:16, 19:18, 21:20 and 23:22 fill slots 0 to 3. A value c places channel vector 30−c in that slot. Eligible slot vectors rank below the promoted vector and above the fixed order, and slot 0 ranks highest.
- R11: An acknowledge with no eligible source latches vector 0, the error vector.
- R12: The control register keeps only bits 7 and 23:8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src | input | NSRC-1 | Source request lines for vectors 1 to NSRC-1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 mask, 2 pending, 3 vector |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected register (combinational) |
| irq_out | output | 1 | Merged request to the core |
| irq_level | output | 3 | Request level programmed for the core |

## Verification
Random runs mix sparse source toggles, random mask, clear and control words, and acknowledges. This compares the arbitration against a model across many mixes of promoted, slotted and fixed-order winners. Directed sequences then separate cases the random mix rarely reaches on its own. These are: an edge racing a clear of the same bit, a source masked before its acknowledge (which must return the error vector rather than a stale winner), a slotted channel beating a higher-numbered plain source, and a promoted low vector beating everything. Readback of the control register with all ones tells held bits from dropped ones.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_MASK = 2'd1,
      RA_PEND = 2'd2,
      RA_VECT = 2'd3
   } vic_addr_e;

   localparam int VEC_W      = 5;
   localparam int CTRL_EN    = 7;
   localparam int PROMO_LSB  = 8;
   localparam int LEVEL_LSB  = 13;
   localparam int LEVEL_W    = 3;
   localparam int SLOT_LSB   = 16;
   localparam int SLOT_W     = 2;
   localparam int NUM_SLOTS  = 4;
   localparam int VEC_LSB    = 11;
   localparam int ACK_BIT    = 0;

endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:1] src,
   input  logic [NSRC-1:1] clr,
   output logic [NSRC-1:1] pend
);

   logic [NSRC-1:1] src_q;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end

   for (genvar i = 1; i < NSRC; i++) begin : g_bit
      logic rise;
      assign rise = src[i] & ~src_q[i];

      always_ff @(posedge clk) begin
         if (!rst_n)      pend[i] <= 1'b0;
         else if (rise)   pend[i] <= 1'b1;
         else if (clr[i]) pend[i] <= 1'b0;
      end

      // R2: an edge always leaves the bit set
      p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (src[i] && !src_q[i]) |=> pend[i]);
      // R3: a clear without a racing edge empties the bit
      p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !(src[i] && !src_q[i])) |=> !pend[i]);
   end

endmodule

// File: rtl/vic_prio.sv
module vic_prio
   import vic_pkg::*;
#(
   parameter int                          NSRC    = 32,
   parameter logic [NUM_SLOTS*VEC_W-1:0]  CH_VECS = {5'd27, 5'd28, 5'd29, 5'd30}
) (
   input  logic [NSRC-1:0]             elig,
   input  logic [VEC_W-1:0]            promo,
   input  logic [NUM_SLOTS*SLOT_W-1:0] slot_sel,
   output logic [VEC_W-1:0]            win,
   output logic                        any_elig
);

   logic [VEC_W-1:0]     fixed_win;
   logic                 promo_hit;
   logic [VEC_W-1:0]     slot_vec [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] slot_hit;

   always_comb begin
      fixed_win = '0;
      for (int i = 1; i < NSRC; i++)
         if (elig[i]) fixed_win = VEC_W'(i);
   end

   always_comb begin
      promo_hit = 1'b0;
      for (int i = 1; i < NSRC; i++)
         if (int'(promo) == i && elig[i]) promo_hit = 1'b1;
   end

   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
      assign slot_vec[k] = CH_VECS[int'(slot_sel[k*SLOT_W +: SLOT_W])*VEC_W +: VEC_W];
      assign slot_hit[k] = elig[slot_vec[k]];
   end

   always_comb begin
      win = fixed_win;
      for (int k = NUM_SLOTS-1; k >= 0; k--)
         if (slot_hit[k]) win = slot_vec[k];
      if (promo_hit) win = promo;
   end

   assign any_elig = |elig;

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
   import vic_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int DW   = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [1:0]                  addr,
   input  logic [DW-1:0]               wdata,
   output logic [DW-1:0]               rdata,
   input  logic [NSRC-1:0]             pend,
   input  logic [VEC_W-1:0]            win,
   input  logic                        any_elig,
   output logic                        en,
   output logic [LEVEL_W-1:0]          level,
   output logic [VEC_W-1:0]            promo,
   output logic [NUM_SLOTS*SLOT_W-1:0] slots,
   output logic [NSRC-1:0]             mask,
   output logic [NSRC-1:1]             clr
);

   localparam int SLOTS_W = NUM_SLOTS * SLOT_W;

   vic_addr_e        sel;
   logic             ack;
   logic [VEC_W-1:0] vec_q;

   assign sel = vic_addr_e'(addr);
   assign ack = wr && sel == RA_VECT && wdata[ACK_BIT];
   assign clr = (wr && sel == RA_PEND) ? wdata[NSRC-1:1] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en    <= 1'b0;
         level <= '0;
         promo <= '0;
         slots <= '0;
      end else if (wr && sel == RA_CTRL) begin
         en    <= wdata[CTRL_EN];
         level <= wdata[LEVEL_LSB +: LEVEL_W];
         promo <= wdata[PROMO_LSB +: VEC_W];
         slots <= wdata[SLOT_LSB +: SLOTS_W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    mask <= '0;
      else if (wr && sel == RA_MASK) mask <= wdata[NSRC-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   vec_q <= '0;
      else if (ack) vec_q <= any_elig ? win : '0;
   end

   always_comb begin
      rdata = '0;
      unique case (sel)
         RA_CTRL: begin
            rdata[CTRL_EN]                = en;
            rdata[PROMO_LSB +: VEC_W]     = promo;
            rdata[LEVEL_LSB +: LEVEL_W]   = level;
            rdata[SLOT_LSB +: SLOTS_W]    = slots;
         end
         RA_MASK: rdata[NSRC-1:0]          = mask;
         RA_PEND: rdata[NSRC-1:0]          = pend;
         RA_VECT: rdata[VEC_LSB +: VEC_W]  = vec_q;
         default: rdata = '0;
      endcase
   end

   // R4: mask takes the written word
   p_mask_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == RA_MASK) |=> mask == $past(wdata[NSRC-1:0]));
   // R6: level follows the control write
   p_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel == RA_CTRL) |=> level == $past(wdata[LEVEL_LSB +: LEVEL_W]));
   // R7: vector holds between acknowledges
   p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> $stable(vec_q));
   // R11: nothing eligible gives the error vector
   p_err_vec_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !any_elig) |=> vec_q == '0);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import vic_pkg::*;
#(
   parameter int                          NSRC    = 32,
   parameter int                          DW      = 32,
   parameter logic [NUM_SLOTS*VEC_W-1:0]  CH_VECS = {5'd27, 5'd28, 5'd29, 5'd30}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:1]      src,
   input  logic                 reg_wr,
   input  logic [1:0]           reg_addr,
   input  logic [DW-1:0]        reg_wdata,
   output logic [DW-1:0]        reg_rdata,
   output logic                 irq_out,
   output logic [LEVEL_W-1:0]   irq_level
);

   localparam int MAX_SRC = 1 << VEC_W;

   if (NSRC < 2 || NSRC > MAX_SRC) begin : g_bad_nsrc
      $error("NSRC must lie in 2..%0d", MAX_SRC);
   end
   if (DW < SLOT_LSB + NUM_SLOTS*SLOT_W || DW < NSRC) begin : g_bad_dw
      $error("DW too narrow for the register layout");
   end
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk_ch
      if (CH_VECS[k*VEC_W +: VEC_W] == 0 || int'(CH_VECS[k*VEC_W +: VEC_W]) >= NSRC) begin : g_bad_ch
         $error("channel vector %0d out of range", k);
      end
   end

   logic [NSRC-1:1]             pend_hi;
   logic [NSRC-1:0]             pend;
   logic [NSRC-1:0]             mask;
   logic [NSRC-1:0]             elig;
   logic [NSRC-1:1]             clr;
   logic                        en;
   logic [VEC_W-1:0]            promo;
   logic [NUM_SLOTS*SLOT_W-1:0] slots;
   logic [VEC_W-1:0]            win;
   logic                        any_elig;

   vic_pend_bank #(.NSRC(NSRC)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .clr   (clr),
      .pend  (pend_hi)
   );

   assign pend = {pend_hi, 1'b0};
   assign elig = pend & mask;

   vic_prio #(.NSRC(NSRC), .CH_VECS(CH_VECS)) u_prio (
      .elig     (elig),
      .promo    (promo),
      .slot_sel (slots),
      .win      (win),
      .any_elig (any_elig)
   );

   vic_regfile #(.NSRC(NSRC), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .pend     (pend),
      .win      (win),
      .any_elig (any_elig),
      .en       (en),
      .level    (irq_level),
      .promo    (promo),
      .slots    (slots),
      .mask     (mask),
      .clr      (clr)
   );

   assign irq_out = en & any_elig;

   // R5: clearing everything with quiet sources drops the request
   p_clear_all_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd2 && (&reg_wdata[NSRC-1:1]) && $stable(src)) |=> !irq_out);

endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
   localparam int NSRC = 32;
   localparam logic [31:0] CTRL_KEEP = 32'h00FF_FF80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [NSRC-1:1] src = '0;
   logic            reg_wr = 1'b0;
   logic [1:0]      reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            irq_out;
   logic [2:0]      irq_level;

   irq_vector_ctrl dut (
      .clk(clk), .rst_n(rst_n), .src(src), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out), .irq_level(irq_level)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   logic [31:0]     m_pend = '0, m_mask = '0, m_ctrl = '0;
   logic [4:0]      m_vec = '0;
   logic [NSRC-1:1] m_src_q = '0;
   logic [NSRC-1:1] cur = '0;

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_win(logic [31:0] p, logic [31:0] m, logic [31:0] c);
      logic [31:0] e;
      logic [4:0]  hp;
      e  = p & m;
      hp = c[12:8];
      if (hp != 0 && e[hp]) return hp;
      for (int k = 0; k < 4; k++) begin
         logic [4:0] v;
         v = 5'd30 - {3'd0, c[16 + 2*k +: 2]};
         if (e[v]) return v;
      end
      for (int i = 31; i >= 1; i--) if (e[i]) return 5'(i);
      return 5'd0;
   endfunction

   task automatic step(logic [NSRC-1:1] s, bit w, logic [1:0] a, logic [31:0] d);
      logic [31:0] edges;
      bit          e_irq;
      @(negedge clk);
      src = s; reg_wr = w; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1;
      reg_wr = 1'b0;
      edges = {s & ~m_src_q, 1'b0};
      if (w && a == 2'd3 && d[0]) m_vec = exp_win(m_pend, m_mask, m_ctrl);
      if (w && a == 2'd1) m_mask = d;
      if (w && a == 2'd0) m_ctrl = d & CTRL_KEEP;
      if (w && a == 2'd2) m_pend = m_pend & ~{d[31:1], 1'b0};
      m_pend  = m_pend | edges;
      m_src_q = s;
      cur     = s;
      e_irq   = m_ctrl[7] && |(m_pend & m_mask);
      chk(irq_out == e_irq, "R5 irq_out", {31'd0, irq_out}, {31'd0, e_irq});
      chk(irq_level == m_ctrl[15:13], "R6 level", {29'd0, irq_level}, {29'd0, m_ctrl[15:13]});
   endtask

   task automatic rd(logic [1:0] a, string req);
      logic [31:0] exp;
      @(negedge clk);
      reg_addr = a;
      #1;
      case (a)
         2'd0: exp = m_ctrl;
         2'd1: exp = m_mask;
         2'd2: exp = m_pend;
         default: exp = {16'd0, m_vec, 11'd0};
      endcase
      chk(reg_rdata == exp, req, reg_rdata, exp);
   endtask

   task automatic ack_and_read(string req);
      step(cur, 1'b1, 2'd3, 32'h1);
      rd(2'd3, req);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running, expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, "R1 ctrl"); rd(2'd1, "R1 mask"); rd(2'd2, "R1 pend"); rd(2'd3, "R1 vect");
      chk(irq_out == 1'b0, "R1 irq_out", {31'd0, irq_out}, 32'd0);
      chk(irq_level == 3'd0, "R1 level", {29'd0, irq_level}, 32'd0);

      // R12 control readback keeps only held bits; R6 level
      step(cur, 1'b1, 2'd0, 32'hFFFF_FFFF);
      rd(2'd0, "R12 ctrl keep");
      step(cur, 1'b1, 2'd0, 32'h0000_4080);   // enable, level 2
      rd(2'd0, "R6 ctrl");

      // R4 mask write/read
      step(cur, 1'b1, 2'd1, 32'hFFFF_FFFF);
      rd(2'd1, "R4 mask");

      // R2 edge sets pending
      step(cur | (31'd1 << 4), 1'b0, 2'd0, 32'd0);   // src[5]
      rd(2'd2, "R2 pend bit5");
      // R3 edge wins over clear, other bit cleared
      step(cur | (31'd1 << 8), 1'b1, 2'd2, 32'h0000_0220); // src[9] rises, clear 5 and 9
      rd(2'd2, "R3 set wins");
      // R8 fixed order
      step(cur | (31'd1 << 4) & ~(31'd1 << 4), 1'b0, 2'd0, 32'd0);
      step(cur & ~(31'd1 << 4), 1'b0, 2'd0, 32'd0);
      step(cur | (31'd1 << 4), 1'b0, 2'd0, 32'd0);  // pend 5 and 9
      ack_and_read("R8 highest wins");
      // R9 promoted vector 5
      step(cur, 1'b1, 2'd0, 32'h0000_0580);
      ack_and_read("R9 promoted");
      // R10 slot 0 -> vector 28 beats 29
      step(cur | (31'd1 << 27) | (31'd1 << 28), 1'b1, 2'd0, 32'h0002_0080);
      ack_and_read("R10 slot beats fixed");
      // R10 slot ordering: slot0 -> 29, slot1 -> 28
      step(cur, 1'b1, 2'd0, 32'h0009_0080);
      ack_and_read("R10 slot order");
      // R5 clearing the last eligible bit drops irq
      step(cur, 1'b1, 2'd2, 32'hFFFF_FFFF);
      rd(2'd2, "R5 pend empty");
      // R11 masked before ack returns error vector
      step(cur & ~(31'd1 << 8), 1'b0, 2'd0, 32'd0);
      step(cur | (31'd1 << 8), 1'b1, 2'd1, 32'h0000_0200);
      step(cur, 1'b1, 2'd1, 32'h0000_0000);
      ack_and_read("R11 error vector");
      // R7 ack works with enable off
      step(cur, 1'b1, 2'd1, 32'hFFFF_FFFF);
      step(cur, 1'b1, 2'd0, 32'h0000_0000);
      ack_and_read("R7 ack while disabled");

      // random mix
      for (int it = 0; it < 600; it++) begin
         logic [NSRC-1:1] s;
         int op;
         s  = cur ^ 31'($urandom & $urandom & $urandom);
         op = int'($urandom % 8);
         case (op)
            0, 1, 2: step(s, 1'b0, 2'd0, 32'd0);
            3: step(s, 1'b1, 2'd1, $urandom | $urandom);
            4: step(s, 1'b1, 2'd2, $urandom & $urandom);
            5: step(s, 1'b1, 2'd0, $urandom | (($urandom % 4 != 0) ? 32'h80 : 32'h0));
            6: begin step(s, 1'b1, 2'd3, 32'h1); rd(2'd3, "R7 R8 R9 R10 random ack"); end
            default: begin step(s, 1'b0, 2'd0, 32'd0); rd(2'd2, "R2 R3 random pend"); end
         endcase
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule